// File: doc/BRIEF.md
# Fractional-N Delta-Sigma Divider Modulator

This block produces the division value that a fractional-N synthesizer applies to its VCO divider on each reference cycle. Each time the reference clock enable is high, it takes one modulator step. The new division value is the programmed integer part plus a small signed correction from the modulator quantizer. Over many cycles the mean correction equals the programmed fraction divided by 2^24, so the mean division ratio is integer + fraction / 2^24.

Software configures the block through a single-cycle register write port. The settings are a 16-bit integer part, a 24-bit fraction, a 24-bit seed and a configuration word. The configuration word selects one of four loop topologies, sets two clamp limits on the quantizer output, and holds an integer-mode flag and an autoseed flag. The seed sets the starting phase of the loop. When autoseed is on, a write to the fraction reloads the loop state from the seed. A separate active-low modulator reset clears the loop state without disturbing the registers.

Top module: `fracn_dsm`

## Requirements
- R1: After `rst_n` the registers hold these values: integer 200, fraction 0, seed 0, order 2'b10, integer mode 0, autoseed 1, clamp maximum +3, clamp minimum -4. Until the first step, `div_out` equals the integer register.
- R2: A write stores `wr_data` at the clock edge. Address 0 takes the integer from bits 15:0. Address 1 takes the fraction from bits 23:0. Address 2 takes the seed from bits 23:0. Address 3 takes the configuration word: order in bits 1:0, integer mode in bit 2, autoseed in bit 3, clamp maximum in bits 7:4 (signed), clamp minimum in bits 11:8 (signed). A step taken at the same edge uses the register values from before the write.
- R3: A step happens at an edge where `ref_ce` is 1, `mod_rst_n` is 1 and no autoseed reload occurs. At a step the output register becomes (integer + sign-extended clamped quantizer value) mod 2^16. At every other edge the output register and the loop state are left unchanged.
- R4: Orders 00, 01 and 10 use error feedback on three 24-bit residues r1, r2, r3 (r1 is the newest). The loop computes u = f + r1 for order 00, u = f + 2r1 - r2 for order 01, and u = f + 3r1 - 3r2 + r3 for order 10. The quantizer value is floor(u / 2^24). The new r1 is u mod 2^24, and the other residues shift down one place.
- R5: Order 11 is a cascade of three 24-bit accumulators. Stage 1 adds f, stage 2 adds the new stage-1 sum, stage 3 adds the new stage-2 sum, and each stage produces a carry c1, c2, c3. The quantizer value is c1 + c2 - c2' + c3 - 2c3' + c3'', where ' marks the value from the previous step and '' the value from two steps back.
- R6: The quantizer value is limited before it is added. If it is above the maximum it becomes the maximum; otherwise, if it is below the minimum, it becomes the minimum.
- R7: A fraction write while autoseed is 1 sets r1 (or the stage-1 accumulator) to the seed and clears all other loop state. It also cancels any step at that same edge, so the output register holds. With autoseed 0, a fraction write changes only the fraction.
- R8: While integer mode is 1, `div_out` equals the integer register, but steps still update the loop state and the output register.
- R9: While `mod_rst_n` is 0, `div_out` equals the integer register, the loop state is cleared and no step is taken. After `mod_rst_n` returns to 1, `div_out` stays equal to the integer register until the first step, which starts from a cleared state.
- R10: Set orders 10 and 11 with clamps of +7 and -8 and a constant fraction f. Over 65536 steps, the sum of the quantizer values is within ±8 of floor(65536·f / 2^24).
- R11: A write to the configuration word does not reload or clear the loop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of registers and loop |
| mod_rst_n | input | 1 | Active-low synchronous reset of the loop state only |
| ref_ce | input | 1 | One modulator step per reference cycle when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 24 | Register write data |
| div_out | output | 16 | Division value for the VCO divider |

## Verification
Two events can fall on the same edge: a step request and an autoseed reload from a fraction write. The bench provokes this directly by raising `ref_ce` in the same cycle as a fraction write, once with autoseed set and once with it cleared. With autoseed set, the reload must win: the output holds and the next step starts from the seed. With autoseed clear, the step must go ahead using the old fraction. A reference model that applies R3 to R9 in the same priority order judges each outcome one cycle later at `div_out`. The random phase mixes writes with enable pulses, so the same collision also arises many more times without being steered.

// File: rtl/fracn_dsm_pkg.sv
package fracn_dsm_pkg;

   typedef enum logic [1:0] {
      ORD_EF1   = 2'b00,
      ORD_EF2   = 2'b01,
      ORD_EF3   = 2'b10,
      ORD_MASH3 = 2'b11
   } dsm_order_e;

   localparam logic [1:0] ADDR_INT  = 2'd0;
   localparam logic [1:0] ADDR_FRAC = 2'd1;
   localparam logic [1:0] ADDR_SEED = 2'd2;
   localparam logic [1:0] ADDR_CFG  = 2'd3;

   localparam int QW    = 4;
   localparam int CFG_W = 2 + 2 + 2 * QW;

   typedef struct packed {
      logic [QW-1:0] qmin;
      logic [QW-1:0] qmax;
      logic          autoseed;
      logic          int_mode;
      dsm_order_e    order;
   } dsm_cfg_t;

   localparam dsm_cfg_t CFG_RESET = '{
      qmin:     4'hC,
      qmax:     4'h3,
      autoseed: 1'b1,
      int_mode: 1'b0,
      order:    ORD_EF3
   };

endpackage

// File: rtl/fracn_dsm_regs.sv
module fracn_dsm_regs
   import fracn_dsm_pkg::*;
#(
   parameter int INT_W     = 16,
   parameter int FRAC_W    = 24,
   parameter int INT_RESET = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [FRAC_W-1:0] wr_data,
   output logic [INT_W-1:0]  int_o,
   output logic [FRAC_W-1:0] frac_o,
   output logic [FRAC_W-1:0] seed_o,
   output dsm_cfg_t          cfg_o,
   output logic              reload_o
);

   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;
   logic [FRAC_W-1:0] seed_q;
   dsm_cfg_t          cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q  <= INT_W'(INT_RESET);
         frac_q <= '0;
         seed_q <= '0;
         cfg_q  <= CFG_RESET;
      end else if (wr_en) begin
         unique case (wr_addr)
            ADDR_INT:  int_q  <= wr_data[INT_W-1:0];
            ADDR_FRAC: frac_q <= wr_data;
            ADDR_SEED: seed_q <= wr_data;
            default:   cfg_q  <= dsm_cfg_t'(wr_data[CFG_W-1:0]);
         endcase
      end
   end

   // reload decision uses the autoseed flag held before this edge
   assign reload_o = wr_en && (wr_addr == ADDR_FRAC) && cfg_q.autoseed;

   assign int_o  = int_q;
   assign frac_o = frac_q;
   assign seed_o = seed_q;
   assign cfg_o  = cfg_q;

endmodule

// File: rtl/fracn_dsm_core.sv
module fracn_dsm_core
   import fracn_dsm_pkg::*;
#(
   parameter int FRAC_W = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mod_rst_n,
   input  logic                 step_i,
   input  logic                 reload_i,
   input  logic [FRAC_W-1:0]    frac_i,
   input  logic [FRAC_W-1:0]    seed_i,
   input  dsm_order_e           order_i,
   output logic signed [QW-1:0] q_raw_o
);

   localparam int NSTG = 3;
   localparam int GW   = 4;
   localparam int U_W  = FRAC_W + GW;

   logic [FRAC_W-1:0] st_q [NSTG];
   logic              c2d_q, c3d_q, c3dd_q;

   // error feedback topologies
   logic signed [U_W-1:0] x_s, s0, s1, s2, u_ef;
   assign x_s = $signed({{GW{1'b0}}, frac_i});
   assign s0  = $signed({{GW{1'b0}}, st_q[0]});
   assign s1  = $signed({{GW{1'b0}}, st_q[1]});
   assign s2  = $signed({{GW{1'b0}}, st_q[2]});

   always_comb begin
      unique case (order_i)
         ORD_EF1: u_ef = x_s + s0;
         ORD_EF2: u_ef = x_s + (s0 <<< 1) - s1;
         default: u_ef = x_s + (s0 <<< 1) + s0 - (s1 <<< 1) - s1 + s2;
      endcase
   end

   // cascaded accumulator topology
   logic [FRAC_W-1:0] m_in  [NSTG];
   logic [FRAC_W-1:0] m_sum [NSTG];
   logic              m_c   [NSTG];

   for (genvar k = 0; k < NSTG; k++) begin : g_stage
      if (k == 0) begin : g_first
         assign m_in[k] = frac_i;
      end else begin : g_chain
         assign m_in[k] = m_sum[k-1];
      end
      assign {m_c[k], m_sum[k]} = {1'b0, st_q[k]} + {1'b0, m_in[k]};
   end

   logic signed [QW:0] y_m;
   assign y_m = $signed({{QW{1'b0}}, m_c[0]})
              + $signed({{QW{1'b0}}, m_c[1]})
              - $signed({{QW{1'b0}}, c2d_q})
              + $signed({{QW{1'b0}}, m_c[2]})
              - $signed({{(QW-1){1'b0}}, c3d_q, 1'b0})
              + $signed({{QW{1'b0}}, c3dd_q});

   assign q_raw_o = (order_i == ORD_MASH3) ? y_m[QW-1:0] : u_ef[U_W-1:FRAC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSTG; i++) st_q[i] <= '0;
         c2d_q  <= 1'b0;
         c3d_q  <= 1'b0;
         c3dd_q <= 1'b0;
      end else if (!mod_rst_n) begin
         for (int i = 0; i < NSTG; i++) st_q[i] <= '0;
         c2d_q  <= 1'b0;
         c3d_q  <= 1'b0;
         c3dd_q <= 1'b0;
      end else if (reload_i) begin
         st_q[0] <= seed_i;
         for (int i = 1; i < NSTG; i++) st_q[i] <= '0;
         c2d_q  <= 1'b0;
         c3d_q  <= 1'b0;
         c3dd_q <= 1'b0;
      end else if (step_i) begin
         if (order_i == ORD_MASH3) begin
            for (int i = 0; i < NSTG; i++) st_q[i] <= m_sum[i];
            c2d_q  <= m_c[1];
            c3d_q  <= m_c[2];
            c3dd_q <= c3d_q;
         end else begin
            st_q[0] <= u_ef[FRAC_W-1:0];
            for (int i = 1; i < NSTG; i++) st_q[i] <= st_q[i-1];
         end
      end
   end

   p_modrst_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_rst_n |=> (st_q[0] == '0 && st_q[1] == '0 && st_q[2] == '0));

   p_seed_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_rst_n && reload_i) |=> (st_q[0] == $past(seed_i) && st_q[1] == '0 && st_q[2] == '0));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_rst_n && !reload_i && !step_i) |=>
         ($stable(st_q[0]) && $stable(st_q[1]) && $stable(st_q[2])));

endmodule

// File: rtl/fracn_dsm_clamp.sv
module fracn_dsm_clamp #(
   parameter int W = 4
) (
   input  logic signed [W-1:0] q_i,
   input  logic signed [W-1:0] qmax_i,
   input  logic signed [W-1:0] qmin_i,
   output logic signed [W-1:0] q_o
);

   always_comb begin
      if (q_i > qmax_i)      q_o = qmax_i;
      else if (q_i < qmin_i) q_o = qmin_i;
      else                   q_o = q_i;
   end

endmodule

// File: rtl/fracn_dsm.sv
module fracn_dsm
   import fracn_dsm_pkg::*;
#(
   parameter int INT_W     = 16,
   parameter int FRAC_W    = 24,
   parameter int INT_RESET = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_rst_n,
   input  logic              ref_ce,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [FRAC_W-1:0] wr_data,
   output logic [INT_W-1:0]  div_out
);

   localparam int EXT_W = INT_W - QW;

   if (FRAC_W < CFG_W) begin : g_bad_frac_cfg
      $error("FRAC_W must hold the configuration word");
   end
   if (FRAC_W < INT_W) begin : g_bad_frac_int
      $error("FRAC_W must be at least INT_W");
   end
   if (INT_W <= QW) begin : g_bad_int
      $error("INT_W must exceed the quantizer width");
   end
   if (INT_RESET < 0 || INT_RESET >= (1 << INT_W)) begin : g_bad_reset
      $error("INT_RESET does not fit INT_W");
   end

   logic [INT_W-1:0]     int_q;
   logic [FRAC_W-1:0]    frac_q, seed_q;
   dsm_cfg_t             cfg_q;
   logic                 reload;
   logic                 step;
   logic signed [QW-1:0] q_raw, q_lim;
   logic [INT_W-1:0]     out_q;
   logic                 byp_q;

   fracn_dsm_regs #(
      .INT_W     (INT_W),
      .FRAC_W    (FRAC_W),
      .INT_RESET (INT_RESET)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .int_o    (int_q),
      .frac_o   (frac_q),
      .seed_o   (seed_q),
      .cfg_o    (cfg_q),
      .reload_o (reload)
   );

   assign step = ref_ce && mod_rst_n && !reload;

   fracn_dsm_core #(
      .FRAC_W (FRAC_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mod_rst_n (mod_rst_n),
      .step_i    (step),
      .reload_i  (reload),
      .frac_i    (frac_q),
      .seed_i    (seed_q),
      .order_i   (cfg_q.order),
      .q_raw_o   (q_raw)
   );

   fracn_dsm_clamp #(
      .W (QW)
   ) u_clamp (
      .q_i    (q_raw),
      .qmax_i ($signed(cfg_q.qmax)),
      .qmin_i ($signed(cfg_q.qmin)),
      .q_o    (q_lim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= INT_W'(INT_RESET);
         byp_q <= 1'b1;
      end else if (!mod_rst_n) begin
         byp_q <= 1'b1;
      end else if (step) begin
         out_q <= int_q + {{EXT_W{q_lim[QW-1]}}, q_lim};
         byp_q <= 1'b0;
      end
   end

   assign div_out = (!mod_rst_n || cfg_q.int_mode || byp_q) ? int_q : out_q;

   p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_ce |=> $stable(out_q));

   p_clamp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(cfg_q.qmin) <= $signed(cfg_q.qmax)) |->
         (q_lim <= $signed(cfg_q.qmax) && q_lim >= $signed(cfg_q.qmin)));

   p_bypass_after_modrst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_rst_n |=> (div_out == int_q));

endmodule

// File: tb/fracn_dsm_tb.sv
`timescale 1ns/1ps
module fracn_dsm_tb;

   localparam longint MASK = 64'hFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_rst_n = 1'b1;
   logic        ref_ce = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [23:0] wr_data = '0;
   logic [15:0] div_out;

   always #10 clk = ~clk;

   fracn_dsm u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mod_rst_n (mod_rst_n),
      .ref_ce    (ref_ce),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .div_out   (div_out)
   );

   int n_cmp = 0;
   int n_bad = 0;
   string tag = "R1";

   // reference model state
   longint m_int, m_frac, m_seed;
   int     m_order, m_qmax, m_qmin;
   bit     m_imode, m_auto, m_byp;
   longint m_st [3];
   int     m_c2d, m_c3d, m_c3dd;
   longint m_out;
   int     last_q;

   function automatic int s4(input int v);
      return (v >= 8) ? v - 16 : v;
   endfunction

   function automatic logic [23:0] cfgw(input int ord, input bit im, input bit au,
                                        input int qmx, input int qmn);
      logic [3:0] a, b;
      a = 4'(qmx);
      b = 4'(qmn);
      return {12'b0, b, a, au, im, 2'(ord)};
   endfunction

   task automatic model_reset();
      m_int = 200; m_frac = 0; m_seed = 0;
      m_order = 2; m_imode = 0; m_auto = 1; m_qmax = 3; m_qmin = -4;
      for (int i = 0; i < 3; i++) m_st[i] = 0;
      m_c2d = 0; m_c3d = 0; m_c3dd = 0;
      m_out = 200; m_byp = 1;
   endtask

   task automatic model_edge(input bit ce, input bit we, input logic [1:0] a,
                             input logic [23:0] d, input bit mr);
      longint u, t0, t1, t2, n0, n1, n2;
      int q, c1, c2, c3;
      if (!mr) begin
         for (int i = 0; i < 3; i++) m_st[i] = 0;
         m_c2d = 0; m_c3d = 0; m_c3dd = 0;
         m_byp = 1;
      end else if (we && a == 2'd1 && m_auto) begin
         m_st[0] = m_seed; m_st[1] = 0; m_st[2] = 0;
         m_c2d = 0; m_c3d = 0; m_c3dd = 0;
      end else if (ce) begin
         if (m_order == 3) begin
            t0 = m_st[0] + m_frac; c1 = int'(t0 >> 24); n0 = t0 & MASK;
            t1 = m_st[1] + n0;     c2 = int'(t1 >> 24); n1 = t1 & MASK;
            t2 = m_st[2] + n1;     c3 = int'(t2 >> 24); n2 = t2 & MASK;
            q = c1 + c2 - m_c2d + c3 - 2 * m_c3d + m_c3dd;
            m_c3dd = m_c3d; m_c2d = c2; m_c3d = c3;
            m_st[0] = n0; m_st[1] = n1; m_st[2] = n2;
         end else begin
            case (m_order)
               0:       u = m_frac + m_st[0];
               1:       u = m_frac + 2 * m_st[0] - m_st[1];
               default: u = m_frac + 3 * m_st[0] - 3 * m_st[1] + m_st[2];
            endcase
            q = int'(u >>> 24);
            m_st[2] = m_st[1]; m_st[1] = m_st[0]; m_st[0] = u & MASK;
         end
         if (q > m_qmax) q = m_qmax;
         else if (q < m_qmin) q = m_qmin;
         last_q = q;
         m_out = (m_int + q) & 64'hFFFF;
         m_byp = 0;
      end
      if (we) begin
         case (a)
            2'd0: m_int  = d & 24'hFFFF;
            2'd1: m_frac = d;
            2'd2: m_seed = d;
            default: begin
               m_order = int'(d[1:0]); m_imode = d[2]; m_auto = d[3];
               m_qmax = s4(int'(d[7:4])); m_qmin = s4(int'(d[11:8]));
            end
         endcase
      end
   endtask

   task automatic check(input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: div_out actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // called at a falling edge; drives, advances the model, waits one cycle, compares
   task automatic cyc(input bit ce, input bit we, input logic [1:0] a,
                      input logic [23:0] d, input bit mr, input bit chk);
      ref_ce = ce; wr_en = we; wr_addr = a; wr_data = d; mod_rst_n = mr;
      model_edge(ce, we, a, d, mr);
      @(negedge clk);
      if (chk) check(div_out, (!mr || m_imode || m_byp) ? m_int[15:0] : m_out[15:0]);
   endtask

   task automatic wr(input logic [1:0] a, input logic [23:0] d);
      cyc(1'b0, 1'b1, a, d, 1'b1, 1'b1);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 24'd0, 1'b1, 1'b1);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic mean_test(input int ord, input logic [23:0] f);
      longint sum, exp, diff;
      logic signed [15:0] dq;
      cyc(1'b0, 1'b0, 2'd0, 24'd0, 1'b0, 1'b1);
      wr(2'd3, cfgw(ord, 0, 1, 7, -8));
      wr(2'd0, 24'd100);
      wr(2'd2, 24'd0);
      wr(2'd1, f);
      sum = 0;
      for (int i = 0; i < 65536; i++) begin
         cyc(1'b1, 1'b0, 2'd0, 24'd0, 1'b1, 1'b1);
         dq = $signed(div_out - 16'd100);
         sum += longint'(dq);
      end
      exp = (65536 * longint'(f)) >> 24;
      diff = sum - exp;
      n_cmp++;
      if (diff > 8 || diff < -8) begin
         n_bad++;
         $display("FAIL R10: order %0d quantizer sum actual %0d expected %0d +/-8", ord, sum, exp);
      end
   endtask

   initial begin
      repeat (199000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
   end

   initial begin
      logic [31:0] r;
      logic signed [15:0] dq;
      r = $urandom(32'h5EED_0417);
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      tag = "R1";
      check(div_out, 16'd200);
      cyc(1'b0, 1'b0, 2'd0, 24'd0, 1'b1, 1'b1);

      tag = "R2";
      wr(2'd0, 24'hAB04D2);
      check(div_out, 16'h04D2);
      wr(2'd2, 24'h5C27E1);
      wr(2'd1, 24'h41A3F9);
      run(20);

      tag = "R4";
      for (int o = 0; o < 3; o++) begin
         wr(2'd3, cfgw(o, 0, 1, 7, -8));
         wr(2'd1, 24'h123457 + 24'(o * 24'h2F0011));
         run(200);
      end

      tag = "R5";
      wr(2'd3, cfgw(3, 0, 1, 7, -8));
      wr(2'd1, 24'hE9137B);
      run(300);

      tag = "R6";
      wr(2'd3, cfgw(2, 0, 1, 1, -1));
      wr(2'd1, 24'h800001);
      for (int i = 0; i < 300; i++) begin
         cyc(1'b1, 1'b0, 2'd0, 24'd0, 1'b1, 1'b1);
         dq = $signed(div_out - m_int[15:0]);
         n_cmp++;
         if (dq > 1 || dq < -1) begin
            n_bad++;
            $display("FAIL R6: clamped value actual %0d expected within -1..1", dq);
         end
      end

      tag = "R7";
      wr(2'd3, cfgw(2, 0, 1, 7, -8));
      wr(2'd2, 24'h0F9E63);
      run(17);
      cyc(1'b1, 1'b1, 2'd1, 24'h2468AC, 1'b1, 1'b1);
      run(30);
      wr(2'd3, cfgw(3, 0, 0, 7, -8));
      run(11);
      cyc(1'b1, 1'b1, 2'd1, 24'h713579, 1'b1, 1'b1);
      run(30);

      tag = "R8";
      wr(2'd3, cfgw(2, 1, 1, 3, -4));
      run(25);
      wr(2'd3, cfgw(2, 0, 1, 3, -4));
      run(25);

      tag = "R9";
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 2'd0, 24'd0, 1'b0, 1'b1);
      cyc(1'b1, 1'b1, 2'd0, 24'd321, 1'b0, 1'b1);
      cyc(1'b0, 1'b0, 2'd0, 24'd0, 1'b1, 1'b1);
      run(40);

      tag = "R11";
      wr(2'd3, cfgw(2, 0, 1, 2, -3));
      run(40);
      wr(2'd3, cfgw(2, 0, 1, 7, -8));
      run(40);

      tag = "R3";
      for (int i = 0; i < 20000; i++) begin
         logic [31:0] p;
         logic [23:0] d;
         bit ce, we, mr;
         p  = $urandom;
         d  = 24'($urandom);
         ce = (p[6:0] < 7'd90);
         we = (p[12:7] < 6'd4);
         mr = (p[19:13] != 7'd0);
         cyc(ce, we, p[21:20], d, mr, 1'b1);
      end

      tag = "R10";
      mean_test(2, 24'h3A5C71);
      mean_test(3, 24'hC1F0A3);

      summary();
   end

endmodule